// File: doc/BRIEF.md
# Half-Word Toggle Pattern Source

This block produces a fixed, repeatable stream of 32-bit words for read-timing calibration of a memory data path that is 16 bits wide. A byte-wide seed counter runs from 0 to 255. Each seed value becomes four output words. For each output word, two bits of the seed choose whether each 16-bit half of the word is all ones or all zeros. Across the whole stream, every pattern of half-word transitions on the bus therefore appears.

The words leave the block on a valid/ready stream. Each word carries its 10-bit position in the stream, and a final flag marks the closing word. The block also has a separate combinational lookup path that returns the expected word for any index. A comparator elsewhere can use it to check read-back data without holding a copy of the pattern. A restart input moves the stream back to its first word at any time.

Top module: `cal_pattern_gen`

## Requirements
- R1: After reset the stream index is 0, valid is high and the word is 0x00000000.
- R2: For word index n, seed s = n[9:2] and slot k = n[1:0]. Bits [15:0] of the word are 0xFFFF when seed bit 2k is set and zero otherwise.
- R3: Bits [31:16] of the same word are 0xFFFF when seed bit 2k+1 is set and zero otherwise.
- R4: The index goes up by exactly one after a cycle in which valid and ready are both high. When ready is low the index, word and last flag keep their values.
- R5: The last flag is high exactly when the index is 1023. The transfer accepted at index 1023 wraps the index to 0.
- R6: When restart is high at a clock edge, the index is 0 after that edge. This holds whether or not a transfer is accepted in the same cycle.
- R7: The lookup output gives the word that R2 and R3 define for the lookup index, in the same cycle and with no register.
- R8: Valid stays high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Return the stream to index 0 |
| out_ready | input | 1 | Sink accepts the current word |
| out_valid | output | 1 | Word available |
| out_data | output | 32 | Pattern word |
| out_index | output | 10 | Position of the word in the stream |
| out_last | output | 1 | Final word of the stream |
| lk_index | input | 10 | Index to look up |
| lk_data | output | 32 | Expected word at lk_index |

## Verification
An accepted transfer and a restart can happen in the same cycle. The bench provokes this by holding ready high while it pulses restart, both in the middle of the stream and on the final word. The reference model expects restart to win, so the next index must be 0 and not the incremented value. The wrap from 1023 to 0 on a plain transfer is also driven, and it is judged apart from the restart case.

// File: rtl/cal_pattern_pkg.sv
package cal_pattern_pkg;
    localparam int SEED_W  = 8;
    localparam int SLOT_W  = 2;
    localparam int IDX_W   = SEED_W + SLOT_W;
    localparam int HALF_W  = 16;
    localparam int WORD_W  = 2 * HALF_W;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [SEED_W-1:0] seed;
        logic [SLOT_W-1:0] slot;
    } pos_t;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } split_word_t;

    function automatic word_t expand(input idx_t n);
        pos_t        p;
        split_word_t w;
        p    = pos_t'(n);
        w.lo = {HALF_W{p.seed[{p.slot, 1'b0}]}};
        w.hi = {HALF_W{p.seed[{p.slot, 1'b1}]}};
        return word_t'(w);
    endfunction
endpackage

// File: rtl/cal_pattern_expand.sv
module cal_pattern_expand
    import cal_pattern_pkg::*;
(
    input  idx_t  idx,
    output word_t word
);
    assign word = expand(idx);
endmodule

// File: rtl/cal_pattern_seq.sv
module cal_pattern_seq
    import cal_pattern_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic advance,
    output idx_t idx,
    output logic at_end
);
    localparam idx_t LAST_IDX = idx_t'((1 << IDX_W) - 1);

    always_ff @(posedge clk) begin
        if (rst || restart) idx <= '0;
        else if (advance)   idx <= idx + idx_t'(1);
    end

    assign at_end = (idx == LAST_IDX);
endmodule

// File: rtl/cal_pattern_gen.sv
module cal_pattern_gen
    import cal_pattern_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        restart,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic [9:0]  out_index,
    output logic        out_last,
    input  logic [9:0]  lk_index,
    output logic [31:0] lk_data
);
    idx_t cur_idx;
    logic xfer;

    assign out_valid = 1'b1;
    assign xfer      = out_valid && out_ready;

    cal_pattern_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .advance (xfer),
        .idx     (cur_idx),
        .at_end  (out_last)
    );

    cal_pattern_expand u_stream_exp (.idx(cur_idx),  .word(out_data));
    cal_pattern_expand u_lookup_exp (.idx(lk_index), .word(lk_data));

    assign out_index = cur_idx;
endmodule

// File: rtl/cal_pattern_gen_chk.sv
module cal_pattern_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        restart,
    input logic        out_ready,
    input logic        out_valid,
    input logic [31:0] out_data,
    input logic [9:0]  out_index,
    input logic        out_last
);
    assert_reset_idx_R1: assert property (@(posedge clk)
        rst |=> (out_index == 10'd0));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!out_ready && !restart) |=> ($stable(out_index) && $stable(out_data) && $stable(out_last)));

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (out_ready && !restart && !out_last) |=> (out_index == $past(out_index) + 10'd1));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (out_ready && out_last) |=> (out_index == 10'd0));

    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        restart |=> (out_index == 10'd0));

    assert_valid_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid);
endmodule

bind cal_pattern_gen cal_pattern_gen_chk u_chk (
    .clk(clk), .rst(rst), .restart(restart), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_index(out_index),
    .out_last(out_last)
);

// File: tb/cal_pattern_gen_bench.sv
module cal_pattern_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        restart = 1'b0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic [9:0]  out_index;
    logic        out_last;
    logic [9:0]  lk_index = '0;
    logic [31:0] lk_data;

    int n_cmp = 0;
    int n_bad = 0;
    int model_idx = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cal_pattern_gen u_cal_pattern_gen (
        .clk(clk), .rst(rst), .restart(restart), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_index(out_index),
        .out_last(out_last), .lk_index(lk_index), .lk_data(lk_data)
    );

    function automatic logic [31:0] ref_word(input int n);
        int s;
        int k;
        logic [31:0] w;
        s = n / 4;
        k = n % 4;
        w = 32'h0;
        if (((s >> (2 * k)) & 1) == 1)     w[15:0]  = 16'hFFFF;
        if (((s >> (2 * k + 1)) & 1) == 1) w[31:16] = 16'hFFFF;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (model idx %0d)", req, act, exp, model_idx);
        end
    endtask

    // Every clock: compare against behavioural model, then advance model.
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R8 valid", {31'b0, out_valid}, 32'd1);
            check("R4/R6 index", {22'b0, out_index}, model_idx[31:0]);
            check("R2/R3 data", out_data, ref_word(model_idx));
            check("R5 last", {31'b0, out_last}, {31'b0, model_idx == 1023});
            check("R7 lookup", lk_data, ref_word(int'(lk_index)));
        end
    end

    always @(posedge clk) begin
        if (rst || restart) model_idx <= 0;
        else if (out_ready) model_idx <= (model_idx + 1) % 1024;
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 idx", {22'b0, out_index}, 32'd0);
        check("R1 data", out_data, 32'h0);
        // R4 stall
        cyc(4);
        // R4 stream with gaps, lookup sweep (R7)
        for (int i = 0; i < 300; i++) begin
            out_ready = (i % 3) != 1;
            lk_index = 10'((i * 37 + 5) % 1024);
            @(negedge clk);
        end
        // R6 restart mid-stream with ready high
        out_ready = 1'b1;
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        check("R6 mid", {22'b0, out_index}, 32'd0);
        // R6 restart while stalled
        out_ready = 1'b0;
        cyc(2);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        // Run to the end: R5 wrap by plain transfer
        out_ready = 1'b1;
        for (int i = 0; i < 1023; i++) begin
            lk_index = 10'(i);
            @(negedge clk);
        end
        check("R5 at end", {31'b0, out_last}, 32'd1);
        check("R2/R3 word 1023", out_data, 32'hFFFFFFFF);
        @(negedge clk);
        check("R5 wrap", {22'b0, out_index}, 32'd0);
        // Run to end again, then restart on the final word (R6 with R5)
        cyc(1023);
        check("R5 last again", {31'b0, out_last}, 32'd1);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        check("R6 on last", {22'b0, out_index}, 32'd0);
        cyc(10);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule